// File: doc/BRIEF.md
# Gated-Input Serial Shift Register

This block is a serial-in/serial-out delay line. On every rising clock edge, each stage takes the value of the stage before it. The bit written into the first stage is the logical AND of two input pins. One pin can therefore carry the data while the other acts as a gate: with the gate high the data passes, and with the gate low zeros are written. Only the final stage is visible outside the block, as a true output and as its inverse. There is no parallel access and no reset pin, so a user empties or fills the register by clocking it.

Each unit holds `STAGES` bits, 8 by default. The top module chains `UNITS` units (2 by default) to form a longer word. The last bit of one unit feeds the data pin of the next unit's AND gate. The gating pin and the clock go to every unit in parallel. A low gate therefore writes a zero into the head of every unit at once. A word shifts in and out serially, first bit first. A new word can enter during the same clocks in which the old one leaves.

Top module: `gsr_cascade`

## Requirements
- R1: On each rising edge, the head stage of the first unit takes `din_a & din_b`. It stores 1 only when both pins are 1.
- R2: A bit written into the head emerges on `dout` after exactly `UNITS*STAGES` rising edges (16 by default) when `din_b` stays 1 throughout.
- R3: Words sent back to back with `din_b`=1 emerge on `dout` in the order they entered, first bit first, with no gap between words.
- R4: After `UNITS*STAGES` consecutive edges with `din_b`=0, every stage holds 0 and `dout` is 0, whatever `din_a` did.
- R5: After `UNITS*STAGES` consecutive edges with `din_a`=`din_b`=1, every stage holds 1 and `dout` is 1.
- R6: While `din_b` is held at 1, `dout` equals `din_a` as it was `UNITS*STAGES` edges earlier.
- R7: `dout_n` is always the inverse of `dout`.
- R8: Unit k>0 takes the previous unit's last bit ANDed with the shared `din_b`. One edge with `din_b`=0 therefore writes a 0 into the head stage of every unit, at positions 0, `STAGES`, 2·`STAGES`, … of the chain.
- R9: Contents are undefined until the register has been flushed. After a flush, every output value follows from R1 to R8 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| din_a | input | 1 | Serial data pin, ANDed with din_b at the chain head |
| din_b | input | 1 | Gating pin, shared by every unit's input gate |
| dout | output | 1 | Last stage of the last unit |
| dout_n | output | 1 | Inverse of dout |

## Verification
The chain is first flushed with the gate held low while `din_a` toggles. This separates a correct AND gate from one that passes `din_a` unconditionally. A run of all-ones follows, then pseudo-random pin pairs covering all four A/B combinations. Next come pseudo-random data with the gate held high, to measure the exact delay, and back-to-back words together with a single isolated 1, to expose a chain that is one stage too long or too short. A single low gate pulse in the middle of a stream of ones must produce one zero for each unit boundary. A wrong cascade connection, such as a gate left out of a later unit, misses one of those zeros.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    localparam int unsigned GSR_UNIT_STAGES = 8;
    localparam int unsigned GSR_UNITS       = 2;

    typedef struct packed {
        logic data;
        logic gate;
    } gsr_pins_t;

    typedef struct packed {
        logic q;
        logic q_n;
    } gsr_tap_t;

    function automatic logic gsr_entry_bit(input gsr_pins_t p);
        return p.data & p.gate;
    endfunction

endpackage

// File: rtl/gsr_gate.sv
module gsr_gate
    import gsr_pkg::*;
(
    input  gsr_pins_t pins,
    output logic      entry
);
    always_comb begin
        entry = gsr_entry_bit(pins);
    end
endmodule

// File: rtl/gsr_chain.sv
module gsr_chain #(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic d,
    output logic head_q,
    output logic tail_q
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [LAST:0] stage_q;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                stage_q[s] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign head_q = stage_q[0];
    assign tail_q = stage_q[LAST];
endmodule

// File: rtl/gsr_unit.sv
module gsr_unit
    import gsr_pkg::*;
#(
    parameter int unsigned STAGES = GSR_UNIT_STAGES
) (
    input  logic     clk,
    input  logic     data_in,
    input  logic     gate_in,
    output gsr_tap_t tap,
    output logic     head_q
);
    gsr_pins_t pins;
    logic      entry;
    logic      tail_q;

    always_comb begin
        pins.data = data_in;
        pins.gate = gate_in;
    end

    gsr_gate u_gate (
        .pins  (pins),
        .entry (entry)
    );

    gsr_chain #(.DEPTH(STAGES)) u_chain (
        .clk    (clk),
        .d      (entry),
        .head_q (head_q),
        .tail_q (tail_q)
    );

    always_comb begin
        tap.q   = tail_q;
        tap.q_n = ~tail_q;
    end
endmodule

// File: rtl/gsr_cascade.sv
module gsr_cascade
    import gsr_pkg::*;
#(
    parameter int unsigned UNITS  = GSR_UNITS,
    parameter int unsigned STAGES = GSR_UNIT_STAGES
) (
    input  logic clk,
    input  logic din_a,
    input  logic din_b,
    output logic dout,
    output logic dout_n
);
    localparam int unsigned TOTAL = UNITS * STAGES;

    gsr_tap_t unit_tap  [UNITS];
    logic     unit_head [UNITS];
    logic     head_bit;

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        logic feed;
        if (u == 0) begin : g_first
            assign feed = din_a;
        end else begin : g_next
            assign feed = unit_tap[u-1].q;
        end

        gsr_unit #(.STAGES(STAGES)) u_unit (
            .clk     (clk),
            .data_in (feed),
            .gate_in (din_b),
            .tap     (unit_tap[u]),
            .head_q  (unit_head[u])
        );
    end

    assign head_bit = unit_head[0];
    assign dout     = unit_tap[UNITS-1].q;
    assign dout_n   = unit_tap[UNITS-1].q_n;
endmodule

// File: rtl/gsr_cascade_chk.sv
module gsr_cascade_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic clk,
    input logic din_a,
    input logic din_b,
    input logic dout,
    input logic dout_n,
    input logic head_bit
);
    localparam int unsigned CW = $clog2(DEPTH + 1) + 1;

    logic          warm     = 1'b0;
    logic [CW-1:0] zero_run = '0;
    logic [CW-1:0] one_run  = '0;

    always_ff @(posedge clk) begin
        warm <= 1'b1;
        if (!din_b) begin
            if (zero_run < CW'(DEPTH)) zero_run <= zero_run + 1'b1;
        end else begin
            zero_run <= '0;
        end
        if (din_a && din_b) begin
            if (one_run < CW'(DEPTH)) one_run <= one_run + 1'b1;
        end else begin
            one_run <= '0;
        end
    end

    AST_ENTRY_IS_AND: assert property (@(posedge clk) disable iff (!warm)
        1'b1 |-> head_bit == ($past(din_a) & $past(din_b))); // R1

    AST_GATE_LOW_CLEARS: assert property (@(posedge clk) disable iff (!warm)
        (zero_run >= CW'(DEPTH)) |-> (dout == 1'b0)); // R4

    AST_ALL_ONES_SETS: assert property (@(posedge clk) disable iff (!warm)
        (one_run >= CW'(DEPTH)) |-> (dout == 1'b1)); // R5

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!warm)
        1'b1 |-> (dout_n == ~dout)); // R7
endmodule

bind gsr_cascade gsr_cascade_chk #(.DEPTH(TOTAL)) chk_i (
    .clk      (clk),
    .din_a    (din_a),
    .din_b    (din_b),
    .dout     (dout),
    .dout_n   (dout_n),
    .head_bit (head_bit)
);

// File: tb/gsr_cascade_tb_top.sv
`timescale 1ns/1ps
module gsr_cascade_tb_top;
    localparam int UNITS  = 2;
    localparam int STAGES = 8;
    localparam int N      = UNITS * STAGES;

    logic clk   = 1'b0;
    logic din_a = 1'b0;
    logic din_b = 1'b0;
    logic dout;
    logic dout_n;

    always #2 clk = ~clk;

    gsr_cascade #(.UNITS(UNITS), .STAGES(STAGES)) dut_i (
        .clk    (clk),
        .din_a  (din_a),
        .din_b  (din_b),
        .dout   (dout),
        .dout_n (dout_n)
    );

    typedef struct {
        bit    exp_q;
        string tag;
    } item_t;

    item_t     sb[$];
    bit        mdl   [N];
    bit        known [N];
    int        checks   = 0;
    int        failures = 0;
    bit        reported = 1'b0;
    bit [15:0] lf       = 16'hACE1;

    function automatic bit [15:0] lfsr_next(input bit [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Driver: applies one pin pair, advances the reference chain, queues the expected output.
    task automatic step(input bit a, input bit b, input string tag);
        @(negedge clk);
        din_a = a;
        din_b = b;
        @(posedge clk);
        for (int i = N - 1; i > 0; i--) begin
            if (i % STAGES == 0) begin
                mdl[i]   = mdl[i-1] & b;
                known[i] = known[i-1] | !b;
            end else begin
                mdl[i]   = mdl[i-1];
                known[i] = known[i-1];
            end
        end
        mdl[0]   = a & b;
        known[0] = 1'b1;
        if (known[N-1]) sb.push_back('{mdl[N-1], tag});
    endtask

    // Monitor: compares each queued expectation at the falling edge after it was produced.
    always @(negedge clk) begin
        item_t it;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (dout !== it.exp_q) begin
                failures++;
                $display("FAIL %s dout actual=%b expected=%b", it.tag, dout, it.exp_q);
            end
            checks++;
            if (dout_n !== ~it.exp_q) begin
                failures++;
                $display("FAIL R7 dout_n actual=%b expected=%b", dout_n, ~it.exp_q);
            end
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mdl[i]   = 1'b0;
            known[i] = 1'b0;
        end
        // R4 / R9: flush with gate low while data toggles.
        for (int i = 0; i < 2 * N; i++) begin
            lf = lfsr_next(lf);
            step(lf[0], 1'b0, "R4");
        end
        // R5: fill with ones.
        for (int i = 0; i < 2 * N; i++) step(1'b1, 1'b1, "R5");
        // R1: all four pin combinations.
        for (int i = 0; i < 3 * N; i++) begin
            lf = lfsr_next(lf);
            step(lf[0], lf[1], "R1");
        end
        // R6: gate held high, random data.
        for (int i = 0; i < 3 * N; i++) begin
            lf = lfsr_next(lf);
            step(lf[3], 1'b1, "R6");
        end
        // R3: back-to-back words, first bit first.
        for (int w = 0; w < 3; w++) begin
            bit [15:0] word;
            word = (w == 0) ? 16'hA5C3 : (w == 1) ? 16'h0F81 : 16'hFFFE;
            for (int i = 0; i < 16; i++) step(word[i], 1'b1, "R3");
        end
        // R2: isolated single 1 in zeros.
        step(1'b1, 1'b1, "R2");
        for (int i = 0; i < N + 4; i++) step(1'b0, 1'b1, "R2");
        // R8: one low gate pulse in a stream of ones.
        for (int i = 0; i < N; i++) step(1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, "R8");
        for (int i = 0; i < N + 2; i++) step(1'b1, 1'b1, "R8");
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        report();
    end

    initial begin
        #80000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end
endmodule